// File: doc/BRIEF.md
# Retention power-domain sequencer

This block steps the control bits of one switchable power domain whose logic keeps its state in retention flip-flops. It holds a 32-bit control image that drives the domain's reset, isolation and clock gate, and also the retention save and restore strobes. A 2-bit domain-type code, captured when a request is accepted, selects the kind of retention handling: none, generic, PCIe PHY or UFS storage.

A power-up request releases the clock gate, then isolation, then reset. It then decides from the type, and from a sticky saved-state flag, whether to replay the retention restore. A power-down request first runs the save pulse for the type, then isolates, gates the clock and asserts reset. For PCIe PHY domains the sequencer inserts counted waits, so that buck isolation can settle. Another agent may rewrite the saved-state flag at any time through an override port.

Top module: `rff_pd_seq`

## Requirements
- R1: After reset the image is 32'h0200_0006: reset-release bit 0 low, isolation bit 1 high, clock-disable bit 2 high, active-low restore strobe bit 25 high, all other bits low. busy and done are low.
- R2: Power-up changes one bit per clock. Bit 2 clears, then bit 1 clears, then bit 0 sets. For type 2 (PCIe PHY), bit 26 (retention clock disable) is set first.
- R3: For type 2, the bit 0 rise follows the bit 1 fall by UP_WAIT_US*CLK_MHZ+1 cycles. On power-down, the bit 2 rise follows the bit 1 rise by DN_WAIT_US*CLK_MHZ+1 cycles. For every other type both gaps are one cycle.
- R4: The restore runs for types 1 and 2 only if bit 27 (saved-state flag) is 1 in the cycle after bit 0 rises. It always runs for type 3 and never runs for type 0.
- R5: Generic (type 1) restore: clear bit 27, set bit 26, drive bit 25 low, drive bit 25 high, clear bit 26.
- R6: PCIe PHY (type 2) restore: clear bit 27, drive bit 25 low, drive bit 25 high, clear bit 26. Without a restore, bit 26 stays set.
- R7: Storage (type 3) restore: set bit 28 (storage clock disable), drive bit 25 low, drive bit 25 high, clear bit 28.
- R8: Power-down save for types 1 and 2: set bit 26, raise bit 24 (save strobe), lower bit 24, clear bit 26, set bit 27. All of this happens before isolation.
- R9: Type 3 save uses bit 28 in place of bit 26 and leaves bit 27 untouched. Type 0 has no save steps.
- R10: The power-down tail sets bit 1, then sets bit 2, then clears bit 0, and then done pulses.
- R11: When flag_wr_en is high, bit 27 takes flag_wr_val on the next clock, unless a sequence step writes bit 27 in that same clock.
- R12: Requests seen while busy are ignored. done is a one-cycle pulse after which busy is low. Simultaneous requests while idle start power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_type | input | 2 | Domain type: 0 none, 1 generic, 2 PCIe PHY, 3 UFS storage |
| up_req | input | 1 | Power-up request, taken while idle |
| dn_req | input | 1 | Power-down request, taken while idle |
| flag_wr_en | input | 1 | External write of the saved-state flag |
| flag_wr_val | input | 1 | Value for the saved-state flag |
| ctl | output | 32 | Control-register image |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs power-up and power-down for every type code, each with the saved-state flag forced to 0 and to 1. It records every change of the control image and compares the list against an ordered model built from the requirements. The two flag values separate a restore that was skipped from one that ran, and the four types separate the save and restore orderings. Gaps are measured from the isolation edge to separate the PCIe waits from the other types. Opposite-direction pokes during a sequence and simultaneous requests while idle test that requests are ignored and that power-up wins.

// File: rtl/rff_pd_seq.sv
module rff_pd_seq #(
  parameter int CLK_MHZ    = 250,
  parameter int UP_WAIT_US = 5,
  parameter int DN_WAIT_US = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  dom_type,
  input  logic        up_req,
  input  logic        dn_req,
  input  logic        flag_wr_en,
  input  logic        flag_wr_val,
  output logic [31:0] ctl,
  output logic        busy,
  output logic        done
);
  localparam int UP_DLY = UP_WAIT_US * CLK_MHZ;
  localparam int DN_DLY = DN_WAIT_US * CLK_MHZ;
  localparam int CW = $clog2((UP_DLY > DN_DLY ? UP_DLY : DN_DLY) + 1);
  localparam int B_RSTB = 0, B_ISO = 1, B_CKDIS = 2;
  localparam int B_SAVE = 24, B_NRES = 25, B_RCK = 26, B_FLAG = 27, B_UCK = 28;
  localparam logic [31:0] RST_IMG = 32'h0200_0006;
  localparam logic [1:0] T_NONE = 2'd0, T_GEN = 2'd1, T_PCIE = 2'd2, T_STOR = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_U_RCK, S_U_CLK, S_U_ISO, S_U_WAIT, S_U_RST, S_U_CHK,
    S_R_FLG, S_R_CKON, S_R_NLO, S_R_NHI, S_R_CKOFF,
    S_D_CKON, S_D_SHI, S_D_SLO, S_D_CKOFF, S_D_FLG,
    S_D_ISO, S_D_WAIT, S_D_CLK, S_D_RST, S_DONE
  } st_t;

  st_t st;
  logic [1:0] typ;
  logic [CW-1:0] cnt;
  logic stor;

  assign stor = (typ == T_STOR);
  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      ctl <= RST_IMG;
      typ <= T_NONE;
      cnt <= '0;
    end else begin
      if (flag_wr_en) ctl[B_FLAG] <= flag_wr_val;
      case (st)
        S_IDLE: begin
          if (up_req) begin
            typ <= dom_type;
            st  <= (dom_type == T_PCIE) ? S_U_RCK : S_U_CLK;
          end else if (dn_req) begin
            typ <= dom_type;
            st  <= (dom_type == T_NONE) ? S_D_ISO : S_D_CKON;
          end
        end
        S_U_RCK: begin ctl[B_RCK] <= 1'b1; st <= S_U_CLK; end
        S_U_CLK: begin ctl[B_CKDIS] <= 1'b0; st <= S_U_ISO; end
        S_U_ISO: begin
          ctl[B_ISO] <= 1'b0;
          if (typ == T_PCIE) begin
            cnt <= CW'(UP_DLY - 1);
            st  <= S_U_WAIT;
          end else st <= S_U_RST;
        end
        S_U_WAIT: if (cnt == '0) st <= S_U_RST; else cnt <= cnt - 1'b1;
        S_U_RST: begin ctl[B_RSTB] <= 1'b1; st <= S_U_CHK; end
        S_U_CHK: begin
          case (typ)
            T_GEN, T_PCIE: st <= ctl[B_FLAG] ? S_R_FLG : S_DONE;
            T_STOR:        st <= S_R_CKON;
            default:       st <= S_DONE;
          endcase
        end
        S_R_FLG: begin
          ctl[B_FLAG] <= 1'b0;
          st <= (typ == T_PCIE) ? S_R_NLO : S_R_CKON;
        end
        S_R_CKON: begin
          if (stor) ctl[B_UCK] <= 1'b1; else ctl[B_RCK] <= 1'b1;
          st <= S_R_NLO;
        end
        S_R_NLO: begin ctl[B_NRES] <= 1'b0; st <= S_R_NHI; end
        S_R_NHI: begin ctl[B_NRES] <= 1'b1; st <= S_R_CKOFF; end
        S_R_CKOFF: begin
          if (stor) ctl[B_UCK] <= 1'b0; else ctl[B_RCK] <= 1'b0;
          st <= S_DONE;
        end
        S_D_CKON: begin
          if (stor) ctl[B_UCK] <= 1'b1; else ctl[B_RCK] <= 1'b1;
          st <= S_D_SHI;
        end
        S_D_SHI: begin ctl[B_SAVE] <= 1'b1; st <= S_D_SLO; end
        S_D_SLO: begin ctl[B_SAVE] <= 1'b0; st <= S_D_CKOFF; end
        S_D_CKOFF: begin
          if (stor) ctl[B_UCK] <= 1'b0; else ctl[B_RCK] <= 1'b0;
          st <= stor ? S_D_ISO : S_D_FLG;
        end
        S_D_FLG: begin ctl[B_FLAG] <= 1'b1; st <= S_D_ISO; end
        S_D_ISO: begin
          ctl[B_ISO] <= 1'b1;
          if (typ == T_PCIE) begin
            cnt <= CW'(DN_DLY - 1);
            st  <= S_D_WAIT;
          end else st <= S_D_CLK;
        end
        S_D_WAIT: if (cnt == '0) st <= S_D_CLK; else cnt <= cnt - 1'b1;
        S_D_CLK: begin ctl[B_CKDIS] <= 1'b1; st <= S_D_RST; end
        S_D_RST: begin ctl[B_RSTB] <= 1'b0; st <= S_DONE; end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rff_pd_seq_chk.sv
module rff_pd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        flag_wr_en,
  input logic [31:0] ctl
);
  p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(flag_wr_en) |-> $countones(ctl ^ $past(ctl)) <= 1);
  p_rst_after_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[0]) |-> !ctl[1] && !ctl[2]);
  p_clk_after_iso_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[2]) |-> ctl[1]);
  p_save_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[24] |-> ctl[26] || ctl[28]);
  p_restore_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[25] |-> ctl[26] || ctl[28]);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !flag_wr_en |=> ctl == $past(ctl));
endmodule

bind rff_pd_seq rff_pd_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .flag_wr_en(flag_wr_en), .ctl(ctl)
);

// File: tb/test_rff_pd_seq.sv
`timescale 1ns/1ps
module test_rff_pd_seq;
  localparam int UP_DLY = 5 * 250;
  localparam int DN_DLY = 1 * 250;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] dom_type = 2'd0;
  logic up_req = 1'b0, dn_req = 1'b0, flag_wr_en = 1'b0, flag_wr_val = 1'b0;
  logic [31:0] ctl;
  logic busy, done;

  int n_chk = 0, n_err = 0;
  logic [31:0] logi [32];
  logic [31:0] expi [32];
  int nlog, nexp;
  logic [31:0] m;

  always #2 clk = ~clk;

  rff_pd_seq i_rff_pd_seq (
    .clk(clk), .rst_n(rst_n), .dom_type(dom_type), .up_req(up_req), .dn_req(dn_req),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val), .ctl(ctl), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic ex(input int b, input bit v);
    if (m[b] != v) begin
      m[b] = v;
      if (nexp < 32) expi[nexp] = m;
      nexp++;
    end
  endtask

  task automatic model(input bit up, input logic [1:0] t);
    bit rs;
    nexp = 0;
    if (up) begin
      if (t == 2'd2) ex(26, 1);
      ex(2, 0); ex(1, 0); ex(0, 1);
      rs = (t == 2'd3) || ((t == 2'd1 || t == 2'd2) && m[27]);
      if (rs) begin
        if (t == 2'd1) begin ex(27, 0); ex(26, 1); ex(25, 0); ex(25, 1); ex(26, 0); end
        if (t == 2'd2) begin ex(27, 0); ex(25, 0); ex(25, 1); ex(26, 0); end
        if (t == 2'd3) begin ex(28, 1); ex(25, 0); ex(25, 1); ex(28, 0); end
      end
    end else begin
      if (t == 2'd1 || t == 2'd2) begin ex(26, 1); ex(24, 1); ex(24, 0); ex(26, 0); ex(27, 1); end
      if (t == 2'd3) begin ex(28, 1); ex(24, 1); ex(24, 0); ex(28, 0); end
      ex(1, 1); ex(2, 1); ex(0, 0);
    end
  endtask

  task automatic run(input bit up, input logic [1:0] t, input bit both, input bit poke,
                     input string tag);
    logic [31:0] prev;
    int cyc, iso_c, sec_c, gap_exp;
    bit fin;
    model(up, t);
    @(negedge clk);
    dom_type = t; up_req = up | both; dn_req = !up | both;
    prev = ctl;
    @(negedge clk);
    up_req = 0; dn_req = 0;
    cyc = 0; fin = 0; nlog = 0; iso_c = -1; sec_c = -1;
    while (!fin && cyc < 5000) begin
      up_req = 0; dn_req = 0;
      if (ctl != prev) begin
        if (nlog < 32) logi[nlog] = ctl;
        nlog++;
        if (ctl[1] != prev[1]) iso_c = cyc;
        if (up && ctl[0] != prev[0]) sec_c = cyc;
        if (!up && ctl[2] != prev[2]) sec_c = cyc;
        prev = ctl;
      end
      if (done) fin = 1;
      else begin
        if (poke && (cyc == 2 || cyc == 6)) begin up_req = !up; dn_req = up; end
        @(negedge clk);
        cyc++;
      end
    end
    chk(fin, tag, "done seen", 64'(fin), 64'd1);
    chk(nlog == nexp, tag, "change count", 64'(nlog), 64'(nexp));
    for (int i = 0; i < nexp && i < nlog && i < 32; i++)
      chk(logi[i] == expi[i], tag, "step image", 64'(logi[i]), 64'(expi[i]));
    gap_exp = (t == 2'd2) ? (up ? UP_DLY + 1 : DN_DLY + 1) : 1;
    chk(sec_c - iso_c == gap_exp, (t == 2'd2) ? "R3" : (up ? "R2" : "R10"),
        "iso gap", 64'(sec_c - iso_c), 64'(gap_exp));
    @(negedge clk);
    chk(!done && !busy, "R12", "after done", {62'd0, done, busy}, 64'd0);
    chk(ctl == m, tag, "final image", 64'(ctl), 64'(m));
  endtask

  task automatic set_flag(input bit f);
    @(negedge clk);
    flag_wr_en = 1; flag_wr_val = f;
    @(negedge clk);
    flag_wr_en = 0;
    m[27] = f;
    chk(ctl[27] == f, "R11", "flag override", 64'(ctl[27]), 64'(f));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    m = 32'h0200_0006;
    repeat (3) @(negedge clk);
    chk(ctl == 32'h0200_0006, "R1", "reset image", 64'(ctl), 64'h0200_0006);
    chk(!busy && !done, "R1", "reset busy/done", {62'd0, busy, done}, 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ctl == 32'h0200_0006, "R1", "image after release", 64'(ctl), 64'h0200_0006);
    for (int t = 0; t < 4; t++) begin
      for (int f = 0; f < 2; f++) begin
        set_flag(f[0]);
        run(1'b1, 2'(t), 1'b0, 1'b0,
            (t == 0) ? "R2" : (f == 0 && t != 3) ? "R4" :
            (t == 1) ? "R5" : (t == 2) ? "R6" : "R7");
        run(1'b0, 2'(t), 1'b0, 1'b0,
            (t == 0) ? "R10" : (t == 3) ? "R9" : "R8");
      end
    end
    set_flag(1'b1);
    run(1'b1, 2'd1, 1'b0, 1'b1, "R12");
    repeat (3) @(negedge clk);
    chk(!busy && ctl == m, "R12", "no late start", 64'(ctl), 64'(m));
    run(1'b0, 2'd3, 1'b0, 1'b1, "R12");
    set_flag(1'b0);
    run(1'b1, 2'd3, 1'b1, 1'b0, "R12");
    chk(ctl[0] == 1'b1, "R12", "both reqs powers up", 64'(ctl[0]), 64'd1);
    run(1'b0, 2'd2, 1'b0, 1'b0, "R8");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule